// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets an external host read and write a bank of 8-bit configuration registers over a two-wire serial bus (I2C-compatible, 7-bit addressing, standard and fast rates). The system clock oversamples the bus lines. Both lines are synchronized and deglitched before the block looks for start, stop and clock edges. The block answers only to a 7-bit device address. The upper six bits of that address are fixed and a strap input supplies the last bit. SDA is driven only through an open-drain enable.

A write carries a register index byte and then any number of data bytes. A read can follow a repeated start in the same transaction, or it can stand alone and use the index left by an earlier command. An internal index moves up by one after every data byte, whether written or read. The register contents are exposed in parallel on a flat bus for the surrounding logic. If SCL stays low too long during a transfer, a timeout counter frees SDA and returns the block to idle.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The block acknowledges, by driving SDA low (sda_oe_o = 1) during the ninth clock, only a device address whose bits [7:1] equal {111000, addr_lsb_i}. Bit 0 is the direction bit (0 = write, 1 = read), so the first byte is 0xE0/0xE1 with the strap low and 0xE2/0xE3 with the strap high.
- R2: In a write, the byte after the address is the register index and every following byte is stored into the indexed register. Every byte is acknowledged, and each byte is taken most significant bit first.
- R3: The index advances by one after each data byte written or read. Only its low log2(N_REGS) bits are kept, so it wraps from the last register to register 0.
- R4: After a register index byte, a repeated start with the read bit returns the indexed register, most significant bit first. SDA is pulled low for 0 bits and released for 1 bits.
- R5: A read transaction with no index byte returns data starting at the index left by the most recent command.
- R6: After the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next start. A stop condition always returns it to idle with SDA released.
- R7: For a non-matching device address, the block does not acknowledge, changes no register and stays silent until the next start.
- R8: Reset sets every register to REG_INIT (all zero by default) and releases SDA.
- R9: If SCL stays low for TIMEOUT_CYC system clocks during a transfer, the block releases SDA and returns to idle, and the next transaction is served normally.
- R10: SCL and SDA are synchronized, and a level counts only after FILT identical samples, so a one-clock pulse on SCL has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_lsb_i | input | 1 | Strap for the device address bit 0 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_o | output | N_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
Writes are issued with data values that have uneven bit patterns, such as 0x81 and 0x3C, so a reversed bit order or a shifted byte gives a wrong register value. Reads are tried after a repeated start and as a standalone transaction. Together these separate a pointer taken from the index byte from one left behind by an earlier access, and multi-byte bursts show the auto-increment, including the wrap from the top register to register 0. Negative patterns show that the block stays silent and keeps its state: the wrong strap value, clocking on after a NACK, a one-clock SCL glitch inside a byte, and SCL held low past the timeout while the block is driving a zero.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int N_REGS = 16,
  parameter int FILT = 3,
  parameter int TIMEOUT_CYC = 3750000,
  parameter logic [N_REGS*8-1:0] REG_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_lsb_i,
  output logic              sda_oe_o,
  output logic [N_REGS*8-1:0] cfg_o
);
  localparam int IW = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [5:0] DEV_HI = 6'b111000;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_SKIP} st_t;
  typedef enum logic [1:0] {K_DEV, K_REG, K_DATA} kind_t;

  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  wire scl_rise  = ~scl_p & scl_f;
  wire scl_fall  = scl_p & ~scl_f;
  wire start_evt = scl_p & scl_f & sda_p & ~sda_f;
  wire stop_evt  = scl_p & scl_f & ~sda_p & sda_f;

  st_t             state;
  kind_t           kind;
  logic [3:0]      cnt;
  logic [7:0]      sh;
  logic [IW-1:0]   ptr;
  logic            rd;
  logic [TW-1:0]   tcnt;
  logic [7:0]      regs [N_REGS];

  wire timeout = (tcnt == TW'(TIMEOUT_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; kind <= K_DEV; cnt <= '0; sh <= '0; ptr <= '0;
      rd <= 1'b0; tcnt <= '0; sda_oe_o <= 1'b0;
      for (int i = 0; i < N_REGS; i++) regs[i] <= REG_INIT[i*8 +: 8];
    end else begin
      if (state == S_IDLE || scl_f) tcnt <= '0;
      else if (!timeout) tcnt <= tcnt + 1'b1;

      if (stop_evt || timeout) begin
        state <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_evt) begin
        state <= S_RX; kind <= K_DEV; cnt <= '0; sda_oe_o <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                K_DEV: begin
                  if (sh[7:1] == {DEV_HI, addr_lsb_i}) begin
                    sda_oe_o <= 1'b1; state <= S_ACK; rd <= sh[0]; kind <= K_REG;
                  end else state <= S_SKIP;
                end
                K_REG: begin
                  ptr <= sh[IW-1:0]; sda_oe_o <= 1'b1; state <= S_ACK; kind <= K_DATA;
                end
                default: begin
                  regs[ptr] <= sh; ptr <= ptr + 1'b1; sda_oe_o <= 1'b1; state <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rd) begin
              state <= S_TX; sh <= regs[ptr]; sda_oe_o <= ~regs[ptr][7];
            end else begin
              state <= S_RX; sda_oe_o <= 1'b0;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe_o <= 1'b0; state <= S_MACK; ptr <= ptr + 1'b1;
            end else begin
              cnt <= cnt + 1'b1; sh <= {sh[6:0], 1'b0}; sda_oe_o <= ~sh[6];
            end
          end
          S_MACK: begin
            if (scl_rise && sda_f) state <= S_SKIP;
            else if (scl_fall) begin
              state <= S_TX; cnt <= '0; sh <= regs[ptr]; sda_oe_o <= ~regs[ptr][7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_REGS; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
  parameter int N_REGS = 16,
  parameter int TIMEOUT_CYC = 3750000,
  parameter logic [N_REGS*8-1:0] REG_INIT = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_f,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic [N_REGS*8-1:0] cfg
);
  localparam int LW = $clog2(TIMEOUT_CYC + 4);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || scl_f) low_cnt <= '0;
    else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
  end

  p_reset_state_r8: assert property (@(posedge clk) rst |=> (!sda_oe && cfg == REG_INIT));
  p_oe_rise_scl_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);
  p_cfg_change_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> !scl_f);
  p_stop_release_r6: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);
  p_timeout_release_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(low_cnt) > TIMEOUT_CYC + 1) |-> !sda_oe);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(
  .N_REGS(N_REGS), .TIMEOUT_CYC(TIMEOUT_CYC), .REG_INIT(REG_INIT)
) chk_i (
  .clk(clk), .rst(rst), .scl_f(scl_f), .stop_evt(stop_evt),
  .sda_oe(sda_oe_o), .cfg(cfg_o)
);

// File: tb/i2c_cfg_slave_tb_top.sv
module i2c_cfg_slave_tb_top;
  localparam int N = 16;
  localparam int TO = 3000;
  localparam int Q = 10;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [N*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_cfg_slave #(.N_REGS(N), .FILT(3), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .addr_lsb_i(strap), .sda_oe_o(sda_oe), .cfg_o(cfg));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(int i);
    return cfg[i*8 +: 8];
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    sda_m = b; wq();
    if (glitch) begin scl = 1'b1; @(negedge clk); scl = 1'b0; wq(); end
    scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); @(negedge clk); b = sda_line;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && i == 4);
    recv_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(input bit do_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!do_ack, 1'b0);
  endtask

  task automatic expect_rd(string t, logic [7:0] v);
    tag_q.push_back(t); exp_q.push_back(v);
  endtask

  task automatic rd_byte(input bit do_ack);
    logic [7:0] v;
    recv_byte(do_ack, v);
    act_q.push_back(v);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0)
        chk(tag_q.pop_front(), 32'(act_q.pop_front()), 32'(exp_q.pop_front()));
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    bit a;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 reset registers", cfg[31:0], 32'h0);
    chk("R8 reset registers hi", cfg[N*8-1 -: 32], 32'h0);
    chk("R8 reset sda release", 32'(sda_oe), 32'h0);

    // R1 R2 R3: write burst to index 2
    i2c_start();
    send_byte(8'hE0, 1'b0, a); chk("R1 address ack", 32'(a), 1);
    send_byte(8'h02, 1'b0, a); chk("R2 index ack", 32'(a), 1);
    send_byte(8'h81, 1'b0, a); chk("R2 data ack", 32'(a), 1);
    send_byte(8'h3C, 1'b0, a);
    i2c_stop();
    chk("R2 reg2 msb first", 32'(rg(2)), 32'h81);
    chk("R3 reg3 auto increment", 32'(rg(3)), 32'h3C);

    // R4: read after repeated start
    i2c_start(); send_byte(8'hE0, 1'b0, a); send_byte(8'h02, 1'b0, a);
    i2c_start(); send_byte(8'hE1, 1'b0, a); chk("R4 read address ack", 32'(a), 1);
    expect_rd("R4 read reg2", 8'h81); rd_byte(1'b1);
    expect_rd("R3 read increments", 8'h3C); rd_byte(1'b0);
    i2c_stop();

    // R5: set index only, then standalone read
    i2c_start(); send_byte(8'hE0, 1'b0, a); send_byte(8'h05, 1'b0, a);
    send_byte(8'hA7, 1'b0, a); send_byte(8'h5B, 1'b0, a); i2c_stop();
    i2c_start(); send_byte(8'hE0, 1'b0, a); send_byte(8'h05, 1'b0, a); i2c_stop();
    i2c_start(); send_byte(8'hE1, 1'b0, a);
    expect_rd("R5 standalone read reg5", 8'hA7); rd_byte(1'b1);
    expect_rd("R5 standalone read reg6", 8'h5B); rd_byte(1'b0);
    // R6: after NACK the slave must not drive reg7 (zero) onto the bus
    recv_byte(1'b0, v);
    chk("R6 silent after nack", 32'(v), 32'hFF);
    i2c_stop();
    chk("R6 released after stop", 32'(sda_oe), 0);

    // R7: wrong address ignored
    i2c_start();
    send_byte(8'hE2, 1'b0, a); chk("R7 no ack wrong address", 32'(a), 0);
    send_byte(8'h02, 1'b0, a); chk("R7 silent after mismatch", 32'(a), 0);
    send_byte(8'h55, 1'b0, a);
    i2c_stop();
    chk("R7 reg2 unchanged", 32'(rg(2)), 32'h81);

    // R1: strap high moves the address
    strap = 1'b1; wq();
    i2c_start(); send_byte(8'hE2, 1'b0, a); chk("R1 strapped address ack", 32'(a), 1);
    send_byte(8'h08, 1'b0, a); send_byte(8'h99, 1'b0, a); i2c_stop();
    chk("R1 strapped write reg8", 32'(rg(8)), 32'h99);
    strap = 1'b0; wq();

    // R3: wrap from top register
    i2c_start(); send_byte(8'hE0, 1'b0, a); send_byte(8'h0F, 1'b0, a);
    send_byte(8'h11, 1'b0, a); send_byte(8'h22, 1'b0, a); i2c_stop();
    chk("R3 top register", 32'(rg(15)), 32'h11);
    chk("R3 wrap to reg0", 32'(rg(0)), 32'h22);

    // R10: one-clock SCL glitch inside a data byte
    i2c_start(); send_byte(8'hE0, 1'b0, a); send_byte(8'h09, 1'b0, a);
    send_byte(8'h6E, 1'b1, a); chk("R10 ack despite glitch", 32'(a), 1);
    i2c_stop();
    chk("R10 glitch ignored reg9", 32'(rg(9)), 32'h6E);

    // R9: hold SCL low while the slave drives a zero bit
    i2c_start(); send_byte(8'hE0, 1'b0, a); send_byte(8'h03, 1'b0, a);
    i2c_start(); send_byte(8'hE1, 1'b0, a);
    repeat (TO / 2) @(negedge clk);
    chk("R9 driving before timeout", 32'(sda_oe), 1);
    repeat (TO) @(negedge clk);
    chk("R9 released after timeout", 32'(sda_oe), 0);
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    i2c_start(); send_byte(8'hE0, 1'b0, a); chk("R9 serves after timeout", 32'(a), 1);
    send_byte(8'h03, 1'b0, a);
    i2c_start(); send_byte(8'hE1, 1'b0, a);
    expect_rd("R9 read after timeout", 8'h3C); rd_byte(1'b0);
    i2c_stop();

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule